// File: doc/BRIEF.md
# I2C Bus Condition and Line Control Register

This block sits beside the byte engine of an I2C master and gives it one 8-bit control register. A register write can make the block generate a START or a STOP condition on the open-drain SDA and SCL lines, drive SDA directly for bus recovery, or pulse a reset to the transfer logic. Register reads return the bus-occupied flag, the level SDA is currently driven to, and the synchronised SCL pin level.

The two lines are modelled as open drain. A `*_pull_o` output at 1 pulls its line low. At 0 the line is released and an external pull-up takes it high. START and STOP waveforms are timed by a half-period counter of `HALF_CNT` clock cycles. The bus-occupied flag follows START and STOP conditions seen on the synchronised pins, whoever drives them, so it also tracks other masters.

Top module: `i2c_line_ctrl`

## Requirements
- R1: After reset, with both lines released and high, the register reads 8'b0111_1101.
- R2: Bits 6, 4, 2 and 0 always read 1 and bit 1 always reads 0. A write that only sets bits 6 and 4 (8'h50) changes neither the read value nor the lines.
- R3: A write with bit 7 = 1, bit 6 = 0 and bit 1 = 0, while in master mode and idle, generates a START. Both lines are released for HALF_CNT cycles. SDA is then pulled low with SCL released for HALF_CNT cycles. Then SCL is pulled low.
- R4: A write with bit 7 = 0, bit 6 = 0 and bit 1 = 0 generates a STOP. Both lines are pulled low for HALF_CNT cycles. SCL is then released. HALF_CNT cycles later SDA is released while SCL is high.
- R5: Bit 7 becomes 1 within SYNC_STAGES+2 cycles of SDA falling while SCL is high on the pins, and becomes 0 within SYNC_STAGES+2 cycles of SDA rising while SCL is high. This holds for any driver of the bus.
- R6: A write with bit 4 = 0 sets the SDA drive: bit 5 = 0 pulls SDA low and bit 5 = 1 releases it. A write with bit 4 = 1 leaves the SDA drive unchanged.
- R7: Bit 5 reads 0 while the block pulls SDA low and 1 while it releases SDA.
- R8: Bit 3 reads the SCL pin level after SYNC_STAGES synchroniser flops.
- R9: A write with bit 1 = 1 ignores every other field of that write. On the next cycle `xfer_rst_o` is 1 for exactly one cycle, both lines are released, any condition being generated is aborted, and bit 7 reads 0.
- R10: The following writes are ignored:
  - a generation request when `master_mode` is 0 or bit 6 is 1;
  - an SDA override while `xfer_active` is 1;
  - any generation request or override while a condition is being generated;
  - the override part of a write that also requests a condition (generation takes priority).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| master_mode | input | 1 | 1 when the interface acts as bus master |
| xfer_active | input | 1 | 1 while a byte transfer is in progress |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_pull_o | output | 1 | 1 pulls SCL low |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| xfer_rst_o | output | 1 | One-cycle reset pulse for the transfer logic |

## Verification
The generator is exercised in four ways:
- **Idle-bus START, then STOP.** The bench measures the exact cycle of each line edge. This separates a correct half-period sequence from one with a wrong edge order or an off-by-one count.
- **Write while generating.** The same commands are issued while a condition is in progress. Overrides and STOP requests must be dropped.
- **Gated writes.** Writes are made with master mode off, with the disable bit set, and with a transfer active. These show each gate working on its own.
- **External driver.** An outside device pulls SDA and SCL. This shows the busy flag and the SCL monitor follow the pins rather than the block's own outputs.

A soft reset issued during an occupied bus confirms that the abort releases both lines and clears the flag.

// File: rtl/i2c_line_pkg.sv
package i2c_line_pkg;
   // Register bit positions (software-visible layout)
   localparam int unsigned BIT_BUSY  = 7;
   localparam int unsigned BIT_GDIS  = 6;
   localparam int unsigned BIT_SDAV  = 5;
   localparam int unsigned BIT_SDAWP = 4;
   localparam int unsigned BIT_SCLM  = 3;
   localparam int unsigned BIT_CRST  = 1;

   typedef enum logic [2:0] {
      GEN_IDLE,
      GEN_S_SETUP,
      GEN_S_HOLD,
      GEN_P_SETUP,
      GEN_P_HOLD
   } gen_state_e;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("i2c_in_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic busy_o
);
   logic sda_prev_q;
   logic start_det;
   logic stop_det;
   logic busy_q;

   assign start_det = scl_s_i &  sda_prev_q & ~sda_s_i;
   assign stop_det  = scl_s_i & ~sda_prev_q &  sda_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_prev_q <= 1'b1;
         busy_q     <= 1'b0;
      end else begin
         sda_prev_q <= sda_s_i;
         if (clr_i || stop_det) busy_q <= 1'b0;
         else if (start_det)    busy_q <= 1'b1;
      end
   end

   assign busy_o = busy_q;

   AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_det && !clr_i |=> busy_o);  // R5
   AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !busy_o);  // R5
   AST_BUSY_OFF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !busy_o);  // R9
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
   import i2c_line_pkg::*;
#(
   parameter int unsigned HALF_CNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort_i,
   input  logic cmd_i,
   input  logic cmd_start_i,
   input  logic ovr_i,
   input  logic ovr_low_i,
   output logic idle_o,
   output logic sda_low_o,
   output logic scl_low_o
);
   localparam int unsigned CNT_W = (HALF_CNT > 2) ? $clog2(HALF_CNT) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HALF_CNT - 1);

   generate
      if (HALF_CNT < 2) begin : g_bad_half
         $error("i2c_cond_gen: HALF_CNT must be at least 2");
      end
   endgenerate

   gen_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sda_low_q;
   logic             scl_low_q;
   logic             cnt_done;

   assign cnt_done = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= GEN_IDLE;
         cnt_q     <= '0;
         sda_low_q <= 1'b0;
         scl_low_q <= 1'b0;
      end else if (abort_i) begin
         st_q      <= GEN_IDLE;
         cnt_q     <= '0;
         sda_low_q <= 1'b0;
         scl_low_q <= 1'b0;
      end else begin
         unique case (st_q)
            GEN_IDLE: begin
               if (cmd_i) begin
                  cnt_q <= CNT_LOAD;
                  if (cmd_start_i) begin
                     st_q      <= GEN_S_SETUP;
                     sda_low_q <= 1'b0;
                     scl_low_q <= 1'b0;
                  end else begin
                     st_q      <= GEN_P_SETUP;
                     sda_low_q <= 1'b1;
                     scl_low_q <= 1'b1;
                  end
               end else if (ovr_i) begin
                  sda_low_q <= ovr_low_i;
               end
            end
            GEN_S_SETUP: begin
               if (cnt_done) begin
                  st_q      <= GEN_S_HOLD;
                  sda_low_q <= 1'b1;
                  cnt_q     <= CNT_LOAD;
               end else cnt_q <= cnt_q - 1'b1;
            end
            GEN_S_HOLD: begin
               if (cnt_done) begin
                  st_q      <= GEN_IDLE;
                  scl_low_q <= 1'b1;
               end else cnt_q <= cnt_q - 1'b1;
            end
            GEN_P_SETUP: begin
               if (cnt_done) begin
                  st_q      <= GEN_P_HOLD;
                  scl_low_q <= 1'b0;
                  cnt_q     <= CNT_LOAD;
               end else cnt_q <= cnt_q - 1'b1;
            end
            GEN_P_HOLD: begin
               if (cnt_done) begin
                  st_q      <= GEN_IDLE;
                  sda_low_q <= 1'b0;
               end else cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= GEN_IDLE;
         endcase
      end
   end

   assign idle_o    = (st_q == GEN_IDLE);
   assign sda_low_o = sda_low_q;
   assign scl_low_o = scl_low_q;

   AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low_o) && $past(st_q) == GEN_S_SETUP |-> !scl_low_o);  // R3
   AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_low_o) && $past(st_q) == GEN_P_HOLD |-> !scl_low_o);  // R4
   AST_BUSY_IGNORES_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_o && st_q != GEN_S_SETUP && st_q != GEN_P_HOLD && !abort_i |=> $stable(sda_low_o));  // R10
endmodule

// File: rtl/i2c_line_ctrl.sv
module i2c_line_ctrl
   import i2c_line_pkg::*;
#(
   parameter int unsigned HALF_CNT    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       master_mode,
   input  logic       xfer_active,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_pull_o,
   output logic       sda_pull_o,
   output logic       xfer_rst_o
);
   logic scl_s;
   logic sda_s;
   logic busy;
   logic gen_idle;
   logic soft_rst;
   logic gen_cmd;
   logic ovr_wr;
   logic xfer_rst_q;
   logic unused_wbits;

   assign unused_wbits = ^{reg_wdata[BIT_SCLM], reg_wdata[2], reg_wdata[0]};

   assign soft_rst = reg_we & reg_wdata[BIT_CRST];
   assign gen_cmd  = reg_we & ~reg_wdata[BIT_CRST] & ~reg_wdata[BIT_GDIS]
                   & master_mode & gen_idle;
   assign ovr_wr   = reg_we & ~reg_wdata[BIT_CRST] & ~reg_wdata[BIT_SDAWP]
                   & ~xfer_active & gen_idle & ~gen_cmd;

   i2c_in_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2c_in_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2c_bus_mon i_mon (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst),
      .scl_s_i(scl_s), .sda_s_i(sda_s), .busy_o(busy));

   i2c_cond_gen #(.HALF_CNT(HALF_CNT)) i_gen (
      .clk(clk), .rst_n(rst_n), .abort_i(soft_rst),
      .cmd_i(gen_cmd), .cmd_start_i(reg_wdata[BIT_BUSY]),
      .ovr_i(ovr_wr), .ovr_low_i(~reg_wdata[BIT_SDAV]),
      .idle_o(gen_idle), .sda_low_o(sda_pull_o), .scl_low_o(scl_pull_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) xfer_rst_q <= 1'b0;
      else        xfer_rst_q <= soft_rst;
   end
   assign xfer_rst_o = xfer_rst_q;

   always_comb begin
      reg_rdata            = 8'b0101_0101;
      reg_rdata[BIT_BUSY]  = busy;
      reg_rdata[BIT_SDAV]  = ~sda_pull_o;
      reg_rdata[BIT_SCLM]  = scl_s;
   end

   AST_SOFT_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> xfer_rst_o && !sda_pull_o && !scl_pull_o);  // R9
   AST_SOFT_RST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rst_o && !soft_rst |=> !xfer_rst_o);  // R9
   AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_wdata[BIT_SDAWP] && reg_wdata[BIT_GDIS] && !reg_wdata[BIT_CRST]
      && gen_idle |=> $stable(sda_pull_o));  // R6
   AST_XFER_BLOCKS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && xfer_active && reg_wdata[BIT_GDIS] && !reg_wdata[BIT_CRST]
      && gen_idle |=> $stable(sda_pull_o));  // R10
   AST_SLAVE_NO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && !master_mode && !reg_wdata[BIT_CRST] && gen_idle |=> gen_idle);  // R10
endmodule

// File: tb/test_i2c_line_ctrl.sv
module test_i2c_line_ctrl;
   localparam int H = 8;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       master_mode = 1'b1;
   logic       xfer_active = 1'b0;
   logic       ext_scl_low = 1'b0;
   logic       ext_sda_low = 1'b0;
   logic       scl_pull_o, sda_pull_o, xfer_rst_o;
   logic       scl_line, sda_line;

   int total = 0;
   int bad = 0;

   assign scl_line = ~(scl_pull_o | ext_scl_low);
   assign sda_line = ~(sda_pull_o | ext_sda_low);

   always #10 clk = ~clk;

   i2c_line_ctrl #(.HALF_CNT(H), .SYNC_STAGES(SYNC)) i_i2c_line_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .master_mode(master_mode), .xfer_active(xfer_active),
      .scl_i(scl_line), .sda_i(sda_line), .scl_pull_o(scl_pull_o),
      .sda_pull_o(sda_pull_o), .xfer_rst_o(xfer_rst_o));

   task automatic chk(input int act, input int exp, input string tag);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // START from idle: SDA low at index H, SCL low at index 2H
   task automatic t_start();
      int t_sda = -1, t_scl = -1, scl_at_sda = -1;
      wr(8'hB0);
      for (int i = 0; i <= 3 * H; i++) begin
         if (t_sda < 0 && sda_pull_o) begin t_sda = i; scl_at_sda = scl_pull_o; end
         if (t_scl < 0 && scl_pull_o) t_scl = i;
         @(negedge clk);
      end
      chk(t_sda, H, "R3 sda fall cycle");
      chk(scl_at_sda, 0, "R3 scl high at sda fall");
      chk(t_scl, 2 * H, "R3 scl fall cycle");
      chk(reg_rdata[7], 1, "R5 busy after start");
      chk(reg_rdata[5], 0, "R7 sda level low after start");
   endtask

   // STOP (8'h00 also asks for override low, which must lose: R10)
   task automatic t_stop(input logic [7:0] d);
      int t_scl = -1, t_sda = -1, scl_at_sda = -1;
      wr(d);
      for (int i = 0; i <= 3 * H; i++) begin
         if (t_scl < 0 && !scl_pull_o) t_scl = i;
         if (t_sda < 0 && !sda_pull_o) begin t_sda = i; scl_at_sda = scl_pull_o; end
         @(negedge clk);
      end
      chk(t_scl, H, "R4 scl release cycle");
      chk(t_sda, 2 * H, "R4 sda release cycle");
      chk(scl_at_sda, 0, "R4 scl high at sda rise");
      chk(reg_rdata[7], 0, "R5 busy cleared after stop");
   endtask

   task automatic t_reset_value();
      chk(reg_rdata, 8'h7D, "R1 reset read value");
      chk({scl_pull_o, sda_pull_o, xfer_rst_o}, 0, "R1 outputs idle");
   endtask

   task automatic t_const_bits();
      wr(8'h50);
      idle(2);
      chk(reg_rdata, 8'h7D, "R2 constant bits after 8'h50");
      chk(sda_pull_o, 0, "R2 no line effect");
   endtask

   task automatic t_override();
      wr(8'h40);
      chk(sda_pull_o, 1, "R6 override pulls sda");
      chk(reg_rdata[5], 0, "R7 reads driven low");
      idle(SYNC + 2);
      chk(reg_rdata[7], 1, "R5 busy from override start");
      wr(8'h50);
      chk(sda_pull_o, 1, "R6 protected write keeps sda");
      wr(8'h60);
      chk(sda_pull_o, 0, "R6 override releases sda");
      chk(reg_rdata[5], 1, "R7 reads released");
      idle(SYNC + 2);
      chk(reg_rdata[7], 0, "R5 busy cleared by override stop");
   endtask

   task automatic t_gates();
      xfer_active = 1'b1;
      wr(8'h40);
      idle(2);
      chk(sda_pull_o, 0, "R10 override ignored during transfer");
      xfer_active = 1'b0;
      master_mode = 1'b0;
      wr(8'hB0);
      idle(3 * H);
      chk({scl_pull_o, sda_pull_o}, 0, "R10 no start outside master mode");
      master_mode = 1'b1;
      wr(8'hF0);
      idle(3 * H);
      chk({scl_pull_o, sda_pull_o}, 0, "R10 no start with disable bit");
   endtask

   task automatic t_busy_gen();
      wr(8'hB0);
      idle(2);
      wr(8'h60);
      wr(8'h30);
      idle(3 * H);
      chk({scl_pull_o, sda_pull_o}, 2'b11, "R10 writes ignored while generating");
   endtask

   task automatic t_soft_reset();
      chk(reg_rdata[7], 1, "R9 busy before soft reset");
      wr(8'h82);
      chk({xfer_rst_o, scl_pull_o, sda_pull_o}, 3'b100, "R9 pulse and release");
      chk(reg_rdata[7], 0, "R9 busy cleared");
      @(negedge clk);
      chk(xfer_rst_o, 0, "R9 pulse one cycle");
      idle(3 * H);
      chk({scl_pull_o, sda_pull_o}, 0, "R9 start field ignored");
   endtask

   task automatic t_external();
      ext_scl_low = 1'b1;
      idle(SYNC);
      chk(reg_rdata[3], 0, "R8 scl monitor low");
      ext_scl_low = 1'b0;
      idle(SYNC);
      chk(reg_rdata[3], 1, "R8 scl monitor high");
      ext_sda_low = 1'b1;
      idle(SYNC + 2);
      chk(reg_rdata[7], 1, "R5 busy from external start");
      ext_sda_low = 1'b0;
      idle(SYNC + 2);
      chk(reg_rdata[7], 0, "R5 idle after external stop");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset_value();
      t_const_bits();
      t_start();
      t_stop(8'h00);
      t_override();
      t_gates();
      t_external();
      t_busy_gen();
      idle(SYNC + 2);
      t_soft_reset();
      t_start();
      t_stop(8'h30);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule